// File: doc/BRIEF.md
# Interrupt Controller

This block collects a bank of interrupt lines, keeps one enable bit and one pending bit per line, and raises a single registered request towards the processor when any enabled line is pending. Next to the request it drives the number of the lowest pending, enabled line and a flag saying that number is meaningful. Software therefore services lines in ascending order: it reads the index, handles the source and acknowledges it, then repeats.

Each line first passes through a synchroniser. A build-time parameter then fixes how pending bits behave, and the same choice applies to every line. In level mode the pending bit is simply the synchronised input and is not stored. In edge mode a rising edge sets a stored bit, and writing 1 to that bit clears it. In AND-clear mode the input level is stored, and a write is ANDed into the pending bits, so a written 0 clears a bit. The register port has one address bit: 0 selects the enable (mask) word and 1 selects the pending (status) word. A read returns its data one cycle after the address is presented.

Top module: `intr_ctrl`

## Requirements
- R1: After reset the mask word reads 0, the status word reads 0, `irq_o` is low and `pend_vld_o` is low.
- R2: A write with `reg_addr_i`=0 replaces the mask word, and reading address 0 returns exactly the written value. A bit value of 1 enables its line. `reg_rdata_o` carries the word that was selected one clock edge earlier.
- R3: An input passes through a two-flop synchroniser. In level mode, an input that changes before clock edge 1 shows on `pend_vld_o` after edge 2 and on `irq_o` after edge 3. In edge mode, such a rise reaches `irq_o` after edge 4 and not before.
- R4: In edge mode, a rising input sets its status bit, and the bit stays set after the input falls. Writing 1 to a status bit clears only that bit. Writing 0 leaves the bit unchanged.
- R5: In level mode, the status word equals the synchronised inputs, and writes to address 1 have no effect.
- R6: In AND-clear mode, a high input sets its status bit, and the bit stays set after the input falls. A write to address 1 leaves status AND write-data, so a written 0 clears a bit and a written 1 keeps it.
- R7: In the stored modes, a status bit is set even while its line is masked. Such a bit raises neither `irq_o` nor `pend_vld_o` until the line is enabled, and does so once it is enabled.
- R8: When a status-clearing write and a new event on the same bit fall in the same cycle, the bit ends up set.
- R9: `irq_o` is a register that goes high one edge after any bit of (status AND mask) is set. It stays low whenever the mask is 0.
- R10: `pend_idx_o` is the lowest bit position set in (status AND mask), and `pend_vld_o` is high exactly when that word is nonzero. With no such bit, the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | NUM_LINES | Asynchronous interrupt inputs |
| reg_addr_i | input | 1 | 0 selects the mask word, 1 selects the status word |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | NUM_LINES | Write data |
| reg_rdata_o | output | NUM_LINES | Read data, one cycle after the address |
| irq_o | output | 1 | Registered request to the processor |
| pend_idx_o | output | IDX_W | Lowest pending enabled line |
| pend_vld_o | output | 1 | `pend_idx_o` is valid |

## Verification
The bench runs all three trigger modes side by side. It sweeps the priority index over every line position with scrambled higher bits and with the lowest bit masked off. A finder that stops on the wrong end, or that ignores the mask, reports a higher line or a disabled one. The bench aims a clearing write at the exact cycle a new edge is detected: a design that lets the clear win loses that interrupt for good. It also writes zeros to edge-mode status and ones to AND-clear status, so a design with the clear polarity inverted wipes pending bits it should keep. It counts edges on the synchroniser path, where one flop too few or too many moves the request by a cycle.

// File: rtl/intr_pkg.sv
package intr_pkg;
   typedef enum logic [1:0] {
      TRIG_LEVEL     = 2'd0,
      TRIG_EDGE      = 2'd1,
      TRIG_AND_CLEAR = 2'd2
   } trig_e;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/intr_latch.sv
module intr_latch
   import intr_pkg::*;
#(
   parameter int    WIDTH = 32,
   parameter trig_e TRIG  = TRIG_EDGE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] status_o
);
   if (TRIG == TRIG_LEVEL) begin : g_level
      logic unused_wr;
      assign unused_wr = ^{wr_i, wdata_i, clk, rst_n};
      assign status_o  = lvl_i;
   end else if (TRIG == TRIG_EDGE) begin : g_edge
      logic [WIDTH-1:0] prev_q, st_q, rise, clr;
      assign rise = lvl_i & ~prev_q;
      assign clr  = wr_i ? wdata_i : '0;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) begin
            prev_q <= '0;
            st_q   <= '0;
         end else begin
            prev_q <= lvl_i;
            st_q   <= (st_q & ~clr) | rise;
         end
      assign status_o = st_q;

      AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((st_q & $past(rise)) == $past(rise))); // R8
      AST_EDGE_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && wdata_i == '0) |=> ((st_q & $past(st_q)) == $past(st_q))); // R4
   end else begin : g_andclr
      logic [WIDTH-1:0] st_q, keep;
      assign keep = wr_i ? wdata_i : '1;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) st_q <= '0;
         else        st_q <= (st_q & keep) | lvl_i;
      assign status_o = st_q;

      AST_ANDCLR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((st_q & $past(lvl_i)) == $past(lvl_i))); // R6
      AST_ANDCLR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((st_q & ~$past(st_q) & ~$past(lvl_i)) == '0)); // R6
   end
endmodule

// File: rtl/intr_prio.sv
module intr_prio #(
   parameter int WIDTH = 32,
   parameter int IDX_W = 5
) (
   input  logic [WIDTH-1:0] pend_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             vld_o
);
   always_comb begin
      idx_o = '0;
      for (int i = WIDTH - 1; i >= 0; i--)
         if (pend_i[i]) idx_o = IDX_W'(i);
   end
   assign vld_o = |pend_i;
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
   import intr_pkg::*;
#(
   parameter int    NUM_LINES   = 32,
   parameter int    SYNC_STAGES = 2,
   parameter trig_e TRIG        = TRIG_EDGE,
   localparam int   IDX_W       = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines_i,
   input  logic                 reg_addr_i,
   input  logic                 reg_we_i,
   input  logic [NUM_LINES-1:0] reg_wdata_i,
   output logic [NUM_LINES-1:0] reg_rdata_o,
   output logic                 irq_o,
   output logic [IDX_W-1:0]     pend_idx_o,
   output logic                 pend_vld_o
);
   localparam logic [NUM_LINES-1:0] ONE = {{(NUM_LINES-1){1'b0}}, 1'b1};

   if (NUM_LINES < 2 || NUM_LINES > 64) begin : g_bad_lines
      $error("intr_ctrl: NUM_LINES must lie in 2..64");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("intr_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NUM_LINES-1:0] lvl, status, mask_q, gated, rdata_q;
   logic                 irq_q;

   intr_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(irq_lines_i), .q_o(lvl));

   intr_latch #(.WIDTH(NUM_LINES), .TRIG(TRIG)) u_latch (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl),
      .wr_i(reg_we_i && reg_addr_i), .wdata_i(reg_wdata_i), .status_o(status));

   assign gated = status & mask_q;

   intr_prio #(.WIDTH(NUM_LINES), .IDX_W(IDX_W)) u_prio (
      .pend_i(gated), .idx_o(pend_idx_o), .vld_o(pend_vld_o));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         mask_q  <= '0;
         rdata_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         if (reg_we_i && !reg_addr_i) mask_q <= reg_wdata_i;
         rdata_q <= reg_addr_i ? status : mask_q;
         irq_q   <= |gated;
      end

   assign reg_rdata_o = rdata_q;
   assign irq_o       = irq_q;

   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_i && !reg_addr_i) |=> (mask_q == $past(reg_wdata_i))); // R2
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |=> !irq_o); // R9
   AST_IDX_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vld_o |-> gated[pend_idx_o]); // R10
   AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vld_o |-> ((gated & ((ONE << pend_idx_o) - ONE)) == '0)); // R10
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_vld_o |-> (gated == '0 && pend_idx_o == '0)); // R10
endmodule

// File: tb/sim_intr_ctrl.sv
module sim_intr_ctrl;
   import intr_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [31:0] lines [3];
   logic        addr  [3];
   logic        we    [3];
   logic [31:0] wd    [3];
   logic [31:0] rdv   [3];
   logic        irq   [3];
   logic [4:0]  idx   [3];
   logic        vld   [3];

   int n_tests = 0;
   int n_fail  = 0;

   // 0: edge mode, 1: level mode, 2: AND-clear mode
   intr_ctrl #(.TRIG(TRIG_EDGE)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_lines_i(lines[0]), .reg_addr_i(addr[0]),
      .reg_we_i(we[0]), .reg_wdata_i(wd[0]), .reg_rdata_o(rdv[0]),
      .irq_o(irq[0]), .pend_idx_o(idx[0]), .pend_vld_o(vld[0]));
   intr_ctrl #(.TRIG(TRIG_LEVEL)) u1 (
      .clk(clk), .rst_n(rst_n), .irq_lines_i(lines[1]), .reg_addr_i(addr[1]),
      .reg_we_i(we[1]), .reg_wdata_i(wd[1]), .reg_rdata_o(rdv[1]),
      .irq_o(irq[1]), .pend_idx_o(idx[1]), .pend_vld_o(vld[1]));
   intr_ctrl #(.TRIG(TRIG_AND_CLEAR)) u2 (
      .clk(clk), .rst_n(rst_n), .irq_lines_i(lines[2]), .reg_addr_i(addr[2]),
      .reg_we_i(we[2]), .reg_wdata_i(wd[2]), .reg_rdata_o(rdv[2]),
      .irq_o(irq[2]), .pend_idx_o(idx[2]), .pend_vld_o(vld[2]));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int m, input logic a, input logic [31:0] d);
      addr[m] = a; wd[m] = d; we[m] = 1'b1;
      tick(1);
      we[m] = 1'b0;
   endtask

   task automatic rd(input int m, input logic a, output logic [31:0] d);
      addr[m] = a; we[m] = 1'b0;
      tick(1);
      d = rdv[m];
   endtask

   function automatic logic [5:0] lowest(input logic [31:0] v);
      logic [5:0] r = 6'd32;
      for (int i = 31; i >= 0; i--) if (v[i]) r = 6'(i);
      return r;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      logic [31:0] pat, msk, g;
      for (int m = 0; m < 3; m++) begin
         lines[m] = '0; addr[m] = 1'b0; we[m] = 1'b0; wd[m] = '0;
      end
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state on every mode
      for (int m = 0; m < 3; m++) begin
         rd(m, 1'b0, d); chk("R1 mask", d, 32'h0);
         rd(m, 1'b1, d); chk("R1 status", d, 32'h0);
         chk("R1 irq", {31'b0, irq[m]}, 32'h0);
         chk("R1 valid", {31'b0, vld[m]}, 32'h0);
      end

      // R2 mask read-back
      for (int k = 0; k < 6; k++) begin
         pat = 32'h1357_9BDF * (k + 1) ^ (32'hF0F0_0F0F >> k);
         wr(0, 1'b0, pat);
         rd(0, 1'b0, d); chk("R2 mask readback", d, pat);
      end

      // R3 edge-mode latency and R4 edge latch
      wr(0, 1'b0, 32'hFFFF_FFFF);
      lines[0] = 32'h0000_0008;
      tick(3); chk("R3 edge irq not before edge 4", {31'b0, irq[0]}, 32'h0);
      tick(1); chk("R3 edge irq at edge 4", {31'b0, irq[0]}, 32'h1);
      lines[0] = 32'h0000_0048;
      tick(4);
      lines[0] = '0;
      tick(4);
      rd(0, 1'b1, d); chk("R4 held after fall", d, 32'h0000_0048);
      wr(0, 1'b1, 32'h0);
      rd(0, 1'b1, d); chk("R4 write 0 keeps", d, 32'h0000_0048);
      wr(0, 1'b1, 32'h0000_0008);
      rd(0, 1'b1, d); chk("R4 write 1 clears one bit", d, 32'h0000_0040);
      chk("R10 idx after clear", {27'b0, idx[0]}, 32'd6);
      wr(0, 1'b1, 32'h0000_0040);
      tick(2); chk("R9 irq drops", {31'b0, irq[0]}, 32'h0);

      // R7 edge capture while masked
      wr(0, 1'b0, 32'h0);
      lines[0] = 32'h0000_0080;
      tick(5);
      chk("R7 masked no irq", {31'b0, irq[0]}, 32'h0);
      chk("R7 masked no valid", {31'b0, vld[0]}, 32'h0);
      rd(0, 1'b1, d); chk("R7 captured while masked", d, 32'h0000_0080);
      wr(0, 1'b0, 32'h0000_0080);
      chk("R7 valid on unmask", {31'b0, vld[0]}, 32'h1);
      chk("R7 idx on unmask", {27'b0, idx[0]}, 32'd7);
      tick(1); chk("R9 irq after unmask", {31'b0, irq[0]}, 32'h1);

      // R8 edge event coincides with clearing write
      wr(0, 1'b0, 32'h0);
      lines[0] = '0;
      wr(0, 1'b1, 32'hFFFF_FFFF);
      tick(4);
      lines[0] = 32'h0000_0200;
      @(posedge clk); @(posedge clk); @(negedge clk);
      addr[0] = 1'b1; wd[0] = 32'h0000_0200; we[0] = 1'b1;
      @(posedge clk); @(negedge clk);
      we[0] = 1'b0;
      rd(0, 1'b1, d); chk("R8 event beats clear", d, 32'h0000_0200);

      // R3 level-mode latency, R5 level follows input
      wr(1, 1'b0, 32'hFFFF_FFFF);
      lines[1] = 32'h0001_0000;
      tick(1); chk("R3 level valid not at edge 1", {31'b0, vld[1]}, 32'h0);
      tick(1); chk("R3 level valid at edge 2", {31'b0, vld[1]}, 32'h1);
      chk("R3 level irq not at edge 2", {31'b0, irq[1]}, 32'h0);
      tick(1); chk("R3 level irq at edge 3", {31'b0, irq[1]}, 32'h1);
      lines[1] = 32'hC003_0500;
      tick(3);
      rd(1, 1'b1, d); chk("R5 status follows", d, 32'hC003_0500);
      wr(1, 1'b1, 32'h0);
      rd(1, 1'b1, d); chk("R5 write 0 ignored", d, 32'hC003_0500);
      wr(1, 1'b1, 32'hFFFF_FFFF);
      rd(1, 1'b1, d); chk("R5 write 1 ignored", d, 32'hC003_0500);
      lines[1] = '0;
      tick(3);
      rd(1, 1'b1, d); chk("R5 status not held", d, 32'h0);

      // R10 priority sweep, all enabled
      for (int i = 0; i < 32; i++) begin
         pat = ((32'hA5C3_9617 ^ (32'h0101_0101 * i)) | (32'd1 << i)) & ~((32'd1 << i) - 1);
         lines[1] = pat;
         tick(3);
         chk($sformatf("R10 sweep idx line %0d", i), {27'b0, idx[1]}, 32'(i));
         chk($sformatf("R10 sweep valid line %0d", i), {31'b0, vld[1]}, 32'h1);
      end
      // R10 sweep with the lowest pending line disabled
      for (int i = 0; i < 32; i++) begin
         msk = ~(32'd1 << i);
         wr(1, 1'b0, msk);
         pat = (32'd1 << i) | (32'd1 << ((i + 5) % 32)) | (32'd1 << ((i + 11) % 32));
         lines[1] = pat;
         tick(3);
         g = pat & msk;
         chk($sformatf("R10 masked sweep line %0d", i), {27'b0, idx[1]}, 32'(lowest(g)));
      end
      wr(1, 1'b0, 32'h0);
      tick(2);
      chk("R9 mask zero irq", {31'b0, irq[1]}, 32'h0);
      chk("R10 none valid", {31'b0, vld[1]}, 32'h0);
      chk("R10 none idx", {27'b0, idx[1]}, 32'h0);

      // R6 AND-clear mode
      wr(2, 1'b0, 32'hFFFF_FFFF);
      lines[2] = 32'h0000_0010;
      tick(4);
      lines[2] = '0;
      tick(4);
      rd(2, 1'b1, d); chk("R6 latched after fall", d, 32'h0000_0010);
      chk("R6 irq held", {31'b0, irq[2]}, 32'h1);
      wr(2, 1'b1, 32'hFFFF_FFFF);
      rd(2, 1'b1, d); chk("R6 write 1 keeps", d, 32'h0000_0010);
      wr(2, 1'b1, ~32'h0000_0010);
      rd(2, 1'b1, d); chk("R6 write 0 clears", d, 32'h0);

      // R8 AND-clear: line still high while written 0
      lines[2] = 32'h0000_0020;
      tick(4);
      wr(2, 1'b1, 32'h0);
      rd(2, 1'b1, d); chk("R8 level beats clear", d, 32'h0000_0020);
      lines[2] = '0;
      tick(3);
      wr(2, 1'b1, 32'h0);

      // R7 AND-clear capture while masked
      wr(2, 1'b0, 32'h0);
      lines[2] = 32'h0000_1000;
      tick(3);
      lines[2] = '0;
      tick(4);
      chk("R7 andclr masked no irq", {31'b0, irq[2]}, 32'h0);
      rd(2, 1'b1, d); chk("R7 andclr captured", d, 32'h0000_1000);
      wr(2, 1'b0, 32'h0000_1000);
      chk("R7 andclr idx", {27'b0, idx[2]}, 32'd12);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule